// File: doc/BRIEF.md
# Lifecycle Transition Sequencer

This block carries out one lifecycle-state transition per reset. From an idle wait it accepts a request, switches the clock source, checks and advances a saturating transition counter, has the target checked for legality, and obtains a hashed unlock token. When RMA is requested it then runs an optional flash wipe, compares both halves of the hashed token with the expected token in two consecutive steps, and finally has the new state programmed into non-volatile storage. Each step talks to an external agent through a simple request level and a done/error pulse pair.

Any failed step ends the sequence in a post-transition sink that reports a result code. Two independent escalation inputs override the sequence and force a terminal escalate state. A device that is already scrapped drops from idle straight into a scrap sink. The state register uses a sparse code. Any value outside that code is trapped in an invalid state that raises a sticky fatal flag and then escalates. Only a reset leaves a sink.

Top module: `lc_xfer_fsm`

## Requirements
- R1: While reset is held, phase_o reads 1 (Reset). On the first clock after release it moves to Idle (2) and waits there while no request is present.
- R2: In Idle, dev_scrapped_i moves the block to Scrap (13) even when req_i is also high. Otherwise req_i moves it to ClkMux (3). A req_i seen in any other state has no effect.
- R3: A request with no failures visits the phases 3,4,5,6,7,8,9,10,11,12 in that order. ClkMux, CntIncr, TransCheck, TokenCheck0 and TokenCheck1 last one cycle each. CntProg, TokenHash, TransProg and FlashRma (with RMA) wait for their done pulse. The matching request output is high only in its own phase, and clk_sel_o is high in phases 3 to 11.
- R4: CntIncr goes to PostTrans with the count error code when cnt_i is at least 24. A counter programming error does the same.
- R5: TransCheck goes to PostTrans with the invalid-transition code when trans_ok_i is low.
- R6: A hash error in TokenHash gives the token error code. A mismatch in the low half of the token, checked in TokenCheck0, or in the high half, checked in TokenCheck1, also gives the token error code. The token is captured on the hash done pulse.
- R7: FlashRma requests a flash wipe only when rma_i is high, and it always continues to TokenCheck0. A flash error is reported from TokenCheck0 as the flash error code.
- R8: TransProg always ends in PostTrans, with the success code or the OTP error code depending on otp_err_i at its done pulse.
- R9: Either escalation input forces Escalate (14) on the next clock from Idle, ClkMux through TransProg, PostTrans or Invalid. Reset and Scrap ignore escalation.
- R10: PostTrans (12), Scrap (13) and Escalate (14) are held until reset.
- R11: A state value outside the legal code moves to Invalid (15) on the next clock and sets fatal_o, which stays high until reset. Invalid then moves to Escalate.
- R12: TokenCheck1 (10) never lasts longer than one cycle.
- R13: result_o is 0 until PostTrans is entered. The codes are 1 success, 2 count error, 3 invalid transition, 4 token error, 5 flash error and 6 OTP error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Transition request |
| dev_scrapped_i | input | 1 | Device already in the scrapped lifecycle state |
| rma_i | input | 1 | Target needs the flash RMA wipe |
| cnt_i | input | CNT_W | Current transition count |
| trans_ok_i | input | 1 | Requested transition is legal |
| cnt_done_i | input | 1 | Counter programming finished |
| cnt_err_i | input | 1 | Counter programming failed (with done) |
| hash_done_i | input | 1 | Token hash ready |
| hash_err_i | input | 1 | Token hashing failed (with done) |
| hash_tok_i | input | TOK_W | Hashed token, valid with hash_done_i |
| exp_tok_i | input | TOK_W | Expected hashed token |
| flash_done_i | input | 1 | Flash wipe finished |
| flash_err_i | input | 1 | Flash wipe failed (with done) |
| otp_done_i | input | 1 | State programming finished |
| otp_err_i | input | 1 | State programming failed (with done) |
| esc0_i | input | 1 | Escalation input, channel 0 |
| esc1_i | input | 1 | Escalation input, channel 1 |
| phase_o | output | 4 | Current phase number (1 to 15) |
| clk_sel_o | output | 1 | Alternate clock selected |
| cnt_req_o | output | 1 | Counter programming request |
| cnt_next_o | output | CNT_W | Count value to program |
| hash_req_o | output | 1 | Token hash request |
| flash_req_o | output | 1 | Flash wipe request |
| otp_req_o | output | 1 | State programming request |
| done_o | output | 1 | In PostTrans |
| result_o | output | 3 | Transition result code |
| scrap_o | output | 1 | In Scrap |
| esc_o | output | 1 | In Escalate |
| fatal_o | output | 1 | Illegal state encoding seen |

## Verification
A corrupted state register is visible at the ports within two clocks. phase_o first shows Invalid with fatal_o high, and one clock later it shows Escalate. A wrong next-state decision shows as a phase_o mismatch one clock after the deciding edge, or as a request output that is high in the wrong phase. A wrong failure path shows as a wrong result_o in PostTrans. The bench injects escalation at every reachable phase on each channel, sweeps every failure point with and without RMA, and sweeps the counter across its limit, so each such fault is caught at the cycle it occurs.

// File: rtl/lc_xfer_fsm.sv
module lc_xfer_fsm #(
  parameter int CNT_W   = 5,
  parameter int CNT_MAX = 24,
  parameter int TOK_W   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             dev_scrapped_i,
  input  logic             rma_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             trans_ok_i,
  input  logic             cnt_done_i,
  input  logic             cnt_err_i,
  input  logic             hash_done_i,
  input  logic             hash_err_i,
  input  logic [TOK_W-1:0] hash_tok_i,
  input  logic [TOK_W-1:0] exp_tok_i,
  input  logic             flash_done_i,
  input  logic             flash_err_i,
  input  logic             otp_done_i,
  input  logic             otp_err_i,
  input  logic             esc0_i,
  input  logic             esc1_i,
  output logic [3:0]       phase_o,
  output logic             clk_sel_o,
  output logic             cnt_req_o,
  output logic [CNT_W-1:0] cnt_next_o,
  output logic             hash_req_o,
  output logic             flash_req_o,
  output logic             otp_req_o,
  output logic             done_o,
  output logic [2:0]       result_o,
  output logic             scrap_o,
  output logic             esc_o,
  output logic             fatal_o
);

  localparam int HALF = TOK_W / 2;
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(CNT_MAX);

  function automatic logic [6:0] enc(input logic [3:0] d);
    return {d, d[1] ^ d[2] ^ d[3], d[0] ^ d[2] ^ d[3], d[0] ^ d[1] ^ d[3]};
  endfunction

  localparam logic [6:0] S_RESET = enc(4'd1);
  localparam logic [6:0] S_IDLE  = enc(4'd2);
  localparam logic [6:0] S_CLK   = enc(4'd3);
  localparam logic [6:0] S_INCR  = enc(4'd4);
  localparam logic [6:0] S_CPROG = enc(4'd5);
  localparam logic [6:0] S_TCHK  = enc(4'd6);
  localparam logic [6:0] S_HASH  = enc(4'd7);
  localparam logic [6:0] S_FLASH = enc(4'd8);
  localparam logic [6:0] S_TOK0  = enc(4'd9);
  localparam logic [6:0] S_TOK1  = enc(4'd10);
  localparam logic [6:0] S_TPROG = enc(4'd11);
  localparam logic [6:0] S_POST  = enc(4'd12);
  localparam logic [6:0] S_SCRAP = enc(4'd13);
  localparam logic [6:0] S_ESC   = enc(4'd14);
  localparam logic [6:0] S_INV   = enc(4'd15);

  localparam logic [2:0] RES_OK    = 3'd1;
  localparam logic [2:0] RES_CNT   = 3'd2;
  localparam logic [2:0] RES_TRANS = 3'd3;
  localparam logic [2:0] RES_TOKEN = 3'd4;
  localparam logic [2:0] RES_FLASH = 3'd5;
  localparam logic [2:0] RES_OTP   = 3'd6;

  logic [6:0]       state_q, state_d;
  logic [2:0]       res_q, res_d;
  logic [TOK_W-1:0] tok_q;
  logic             fbad_q, fatal_q;
  logic             legal, esc_any, esc_able;

  assign legal    = (state_q[6:3] != 4'd0) && (enc(state_q[6:3]) == state_q);
  assign esc_any  = esc0_i | esc1_i;
  assign esc_able = legal && state_q != S_RESET && state_q != S_SCRAP && state_q != S_ESC;

  always_comb begin
    state_d = state_q;
    res_d   = res_q;
    case (state_q)
      S_RESET: state_d = S_IDLE;
      S_IDLE:  if (dev_scrapped_i) state_d = S_SCRAP;
               else if (req_i)     state_d = S_CLK;
      S_CLK:   state_d = S_INCR;
      S_INCR:  if (cnt_i >= CNT_LIM) begin
                 state_d = S_POST; res_d = RES_CNT;
               end else state_d = S_CPROG;
      S_CPROG: if (cnt_done_i) begin
                 if (cnt_err_i) begin state_d = S_POST; res_d = RES_CNT; end
                 else state_d = S_TCHK;
               end
      S_TCHK:  if (trans_ok_i) state_d = S_HASH;
               else begin state_d = S_POST; res_d = RES_TRANS; end
      S_HASH:  if (hash_done_i) begin
                 if (hash_err_i) begin state_d = S_POST; res_d = RES_TOKEN; end
                 else state_d = S_FLASH;
               end
      S_FLASH: if (!rma_i || flash_done_i) state_d = S_TOK0;
      S_TOK0:  if (fbad_q) begin
                 state_d = S_POST; res_d = RES_FLASH;
               end else if (tok_q[HALF-1:0] == exp_tok_i[HALF-1:0]) state_d = S_TOK1;
               else begin state_d = S_POST; res_d = RES_TOKEN; end
      S_TOK1:  if (tok_q[TOK_W-1:HALF] == exp_tok_i[TOK_W-1:HALF]) state_d = S_TPROG;
               else begin state_d = S_POST; res_d = RES_TOKEN; end
      S_TPROG: if (otp_done_i) begin
                 state_d = S_POST;
                 res_d   = otp_err_i ? RES_OTP : RES_OK;
               end
      S_POST, S_SCRAP, S_ESC: state_d = state_q;
      S_INV:   state_d = S_ESC;
      default: state_d = S_INV;
    endcase
    if (esc_any && esc_able) state_d = S_ESC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_RESET;
      res_q   <= 3'd0;
      tok_q   <= '0;
      fbad_q  <= 1'b0;
      fatal_q <= 1'b0;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
      if (state_q == S_HASH && hash_done_i) tok_q <= hash_tok_i;
      if (state_q == S_FLASH && rma_i && flash_done_i && flash_err_i) fbad_q <= 1'b1;
      if (!legal) fatal_q <= 1'b1;
    end
  end

  assign phase_o     = state_q[6:3];
  assign clk_sel_o   = legal && phase_o >= 4'd3 && phase_o <= 4'd11;
  assign cnt_req_o   = state_q == S_CPROG;
  assign cnt_next_o  = cnt_i + CNT_W'(1);
  assign hash_req_o  = state_q == S_HASH;
  assign flash_req_o = state_q == S_FLASH && rma_i;
  assign otp_req_o   = state_q == S_TPROG;
  assign done_o      = state_q == S_POST;
  assign result_o    = res_q;
  assign scrap_o     = state_q == S_SCRAP;
  assign esc_o       = state_q == S_ESC;
  assign fatal_o     = fatal_q;

  AST_RESET_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_RESET |=> state_q == S_IDLE); // R1
  AST_IDLE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_IDLE && req_i && !dev_scrapped_i && !esc_any |=> state_q == S_CLK); // R2
  AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_INCR && cnt_i >= CNT_LIM && !esc_any |=> state_q == S_POST && res_q == RES_CNT); // R4
  AST_ESC_OVERRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc_any && legal && phase_o >= 4'd2 && phase_o <= 4'd12 |=> state_q == S_ESC); // R9
  AST_ESC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_ESC |=> state_q == S_ESC); // R10
  AST_SCRAP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_SCRAP |=> state_q == S_SCRAP); // R10
  AST_POST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_POST && !esc_any |=> state_q == S_POST && $stable(res_q)); // R10
  AST_ILLEGAL_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legal |=> state_q == S_INV && fatal_o); // R11
  AST_FATAL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |=> fatal_o); // R11
  AST_TOK1_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_TOK1 |=> state_q != S_TOK1); // R12
  AST_REQ_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cnt_req_o, hash_req_o, flash_req_o, otp_req_o})); // R3

endmodule

// File: tb/lc_xfer_fsm_tb_top.sv
module lc_xfer_fsm_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] GOOD_TOK = 16'hA55A;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 0, dev_scrapped_i = 0, rma_i = 0, trans_ok_i = 1;
  logic [4:0] cnt_i = 5'd3;
  logic cnt_done_i = 0, cnt_err_i = 0, hash_done_i = 0, hash_err_i = 0;
  logic [15:0] hash_tok_i = 16'h0, exp_tok_i = GOOD_TOK;
  logic flash_done_i = 0, flash_err_i = 0, otp_done_i = 0, otp_err_i = 0;
  logic esc0_i = 0, esc1_i = 0;
  logic [3:0] phase_o;
  logic clk_sel_o, cnt_req_o, hash_req_o, flash_req_o, otp_req_o;
  logic done_o, scrap_o, esc_o, fatal_o;
  logic [4:0] cnt_next_o;
  logic [2:0] result_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lc_xfer_fsm dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .dev_scrapped_i(dev_scrapped_i),
    .rma_i(rma_i), .cnt_i(cnt_i), .trans_ok_i(trans_ok_i),
    .cnt_done_i(cnt_done_i), .cnt_err_i(cnt_err_i),
    .hash_done_i(hash_done_i), .hash_err_i(hash_err_i),
    .hash_tok_i(hash_tok_i), .exp_tok_i(exp_tok_i),
    .flash_done_i(flash_done_i), .flash_err_i(flash_err_i),
    .otp_done_i(otp_done_i), .otp_err_i(otp_err_i),
    .esc0_i(esc0_i), .esc1_i(esc1_i),
    .phase_o(phase_o), .clk_sel_o(clk_sel_o), .cnt_req_o(cnt_req_o),
    .cnt_next_o(cnt_next_o), .hash_req_o(hash_req_o), .flash_req_o(flash_req_o),
    .otp_req_o(otp_req_o), .done_o(done_o), .result_o(result_o),
    .scrap_o(scrap_o), .esc_o(esc_o), .fatal_o(fatal_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic quiet_inputs();
    req_i = 0; dev_scrapped_i = 0; rma_i = 0; trans_ok_i = 1; cnt_i = 5'd3;
    cnt_done_i = 0; cnt_err_i = 0; hash_done_i = 0; hash_err_i = 0;
    hash_tok_i = 16'h0; flash_done_i = 0; flash_err_i = 0;
    otp_done_i = 0; otp_err_i = 0; esc0_i = 0; esc1_i = 0;
  endtask

  task automatic do_reset();
    quiet_inputs();
    @(negedge clk);
    rst_ni = 0;
    repeat (2) @(negedge clk);
    chk(phase_o == 4'd1, "R1 reset phase", phase_o, 1);
    chk(result_o == 3'd0 && !fatal_o && !done_o, "R13 reset result", result_o, 0);
    rst_ni = 1;
  endtask

  // fail: 0 none, 1 count limit, 2 count prog err, 3 illegal target, 4 hash err,
  // 5 low-half mismatch, 6 high-half mismatch, 7 flash err, 8 otp err
  task automatic run(input int fail, input bit rma, input int esc_at, input bit esc_sel,
                     input int cnt, input bit scrapped, input string tag);
    int expph, nx, res, w;
    bit fb, e, dn;
    do_reset();
    rma_i = rma; cnt_i = 5'(cnt); dev_scrapped_i = scrapped;
    expph = 1; res = 0; w = 0; fb = 0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      chk(phase_o == 4'(expph), tag, phase_o, expph);
      chk({clk_sel_o, cnt_req_o, hash_req_o, flash_req_o, otp_req_o, done_o, scrap_o, esc_o} ==
          {expph >= 3 && expph <= 11, expph == 5, expph == 7, expph == 8 && rma,
           expph == 11, expph == 12, expph == 13, expph == 14},
          "R3 request outputs", {clk_sel_o, cnt_req_o, hash_req_o, flash_req_o, otp_req_o,
          done_o, scrap_o, esc_o}, 0);
      chk(result_o == 3'(res), "R13 result code", result_o, res);
      if (expph == 5) chk(cnt_next_o == 5'(cnt + 1), "R3 next count", cnt_next_o, cnt + 1);
      req_i = (cyc >= 2);
      e = (esc_at == expph);
      esc0_i = e && !esc_sel;
      esc1_i = e && esc_sel;
      dn = (w == 1);
      cnt_done_i = (expph == 5) && dn;   cnt_err_i = (fail == 2);
      trans_ok_i = (fail != 3);
      hash_done_i = (expph == 7) && dn;  hash_err_i = (fail == 4);
      hash_tok_i = hash_done_i ? (GOOD_TOK ^ (fail == 5 ? 16'h0001 : fail == 6 ? 16'h0100 : 16'h0))
                               : 16'hDEAD;
      flash_done_i = (expph == 8) && dn; flash_err_i = (fail == 7);
      otp_done_i = (expph == 11) && dn;  otp_err_i = (fail == 8);
      nx = expph;
      case (expph)
        1: nx = 2;
        2: nx = scrapped ? 13 : (req_i ? 3 : 2);
        3: nx = 4;
        4: if (cnt >= 24) begin nx = 12; res = 2; end else nx = 5;
        5: if (dn) begin if (fail == 2) begin nx = 12; res = 2; end else nx = 6; end
        6: if (fail == 3) begin nx = 12; res = 3; end else nx = 7;
        7: if (dn) begin if (fail == 4) begin nx = 12; res = 4; end else nx = 8; end
        8: if (!rma) nx = 9; else if (dn) begin nx = 9; fb = (fail == 7); end
        9: if (fb) begin nx = 12; res = 5; end
           else if (fail == 5) begin nx = 12; res = 4; end else nx = 10;
        10: if (fail == 6) begin nx = 12; res = 4; end else nx = 11;
        11: if (dn) begin nx = 12; res = (fail == 8) ? 6 : 1; end
        15: nx = 14;
        default: nx = expph;
      endcase
      if (e && expph >= 2 && expph != 13 && expph != 14) nx = 14;
      w = (nx == expph) ? w + 1 : 0;
      @(negedge clk);
      if (expph == 10) chk(phase_o != 4'd10, "R12 token check 1 single cycle", phase_o, nx);
      if (expph >= 12 && expph <= 14 && nx == expph)
        chk(phase_o == 4'(expph), "R10 sink held", phase_o, expph);
      expph = nx;
    end
    quiet_inputs();
  endtask

  task automatic illegal_test();
    do_reset();
    repeat (3) @(negedge clk);
    chk(phase_o == 4'd2, "R1 idle without request", phase_o, 2);
    force dut_i.state_q = 7'b0000001;
    #1;
    release dut_i.state_q;
    @(negedge clk);
    chk(phase_o == 4'd15, "R11 invalid phase", phase_o, 15);
    chk(fatal_o == 1'b1, "R11 fatal flag", fatal_o, 1);
    @(negedge clk);
    chk(phase_o == 4'd14, "R11 invalid escalates", phase_o, 14);
    repeat (3) @(negedge clk);
    chk(fatal_o == 1'b1 && phase_o == 4'd14, "R11 fatal sticky", fatal_o, 1);
  endtask

  initial begin
    quiet_inputs();
    for (int f = 0; f <= 8; f++)
      for (int r = 0; r < 2; r++)
        run(f, r[0], 0, 1'b0, 3, 1'b0,
            f == 0 ? "R3 chain" : f <= 2 ? "R4 count" : f == 3 ? "R5 illegal target" :
            f <= 6 ? "R6 token" : f == 7 ? "R7 flash" : "R8 program");
    for (int c = 20; c <= 31; c++) run(0, 1'b0, 0, 1'b0, c, 1'b0, "R4 count limit");
    for (int p = 1; p <= 12; p++)
      for (int s = 0; s < 2; s++) run(0, 1'b1, p, s[0], 3, 1'b0, "R9 escalation");
    run(0, 1'b0, 11, 1'b1, 3, 1'b0, "R9 escalation in TransProg");
    for (int s = 0; s < 2; s++) run(0, 1'b0, 13, s[0], 3, 1'b1, "R2 scrap");
    illegal_test();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule